// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block hands the external system bus to another master on request. A hold request from outside is registered, and once the cycle the internal bus controller is running has reached its end, the arbiter grants the bus. It raises an acknowledge output and stops driving the address/data and control outputs. The arbiter follows the length of the running cycle from a start strobe and a kind code given by the bus controller. For that reason, the grant latency depends on whether the cycle is internal, a 16-bit external cycle or an 8-bit external cycle.

While the bus is granted away, a stall output holds the controller back, and no new cycle can start. If the controller has an external cycle waiting during that time, a bus-request output tells the outside master that the internal side needs the bus. When the request is withdrawn, the acknowledge drops first. The outputs are driven again one state later, and then the stalled cycle may go ahead. A select bit turns the whole feature on. When it is clear, the request input has no effect.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, `grant` is 0, `busReq` is 0, `stall` is 0 and `drvEn` is 1.
- R2: While `holdEn` is 0, `holdReq` is ignored: `grant` and `busReq` stay 0 and `drvEn` stays 1.
- R3: With the bus idle, a `holdReq` that is high at clock edge H gives `grant` = 1 from edge H+1 on, counting edge H as the edge that registers the request.
- R4: A cycle accepted at edge S occupies the bus for a number of states set by `cycKind`: 0 internal = 2, 1 external 16-bit = 3, 2 or 3 external 8-bit = 5. `grant` cannot rise before edge S+len. With a request registered at H ≥ S, `grant` rises at edge max(H+1, S+len).
- R5: When `cycStart` is high at the same edge at which a registered request would otherwise be granted, the cycle wins and the grant waits for it to end.
- R6: While `grant` is 1, `drvEn` is 0 and `stall` is 1.
- R7: When the request is withdrawn, `grant` falls one edge after the edge that registers the low request, with `drvEn` still 0 and `stall` still 1. `drvEn` returns to 1 and `stall` returns to 0 one edge later.
- R8: `busReq` is 1 after an edge exactly when the arbiter is in the granted state after that edge and `extPending` was high at that edge. It falls at the edge at which the grant ends.
- R9: A `cycStart` while `stall` is 1 is not accepted and does not occupy the bus afterwards.
- R10: Clearing `holdEn` while granted releases the bus with the same ordering as R7, one edge earlier, since no request register is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rstN | input | 1 | Asynchronous reset, active low |
| holdEn | input | 1 | Feature select; when 0 the hold request is ignored |
| holdReq | input | 1 | External master asks for the bus, active high |
| cycStart | input | 1 | Bus controller starts a cycle at this edge |
| cycKind | input | 2 | Kind of the cycle started: 0 internal, 1 external 16-bit, 2/3 external 8-bit |
| extPending | input | 1 | Controller has an external cycle waiting |
| grant | output | 1 | Bus handed to the external master (acknowledge) |
| drvEn | output | 1 | Enable for the address/data and control output drivers |
| stall | output | 1 | Holds the bus controller off the bus |
| busReq | output | 1 | Internal side wants the bus back while it is granted |

## Verification
Every result is due after a fixed count of registered edges. The request takes one edge to be registered and the grant one edge more. A running cycle ends len edges after its start, and each release step takes one edge. `busReq` follows its inputs by one edge. The bench gives each input pattern an edge index and works out from R3–R5 the edge at which the grant must rise. It drives inputs and samples outputs at the falling clock edge between those edges, so each check falls in the state just after the edge it predicts. The sweep covers every cycle kind and request offsets before, at, and after the cycle start.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_GRANT   = 2'd1,
    ST_RELEASE = 2'd2
  } arbState_t;

  typedef enum logic [1:0] {
    KIND_INT    = 2'd0,
    KIND_WIDE   = 2'd1,
    KIND_NARROW = 2'd2,
    KIND_SPARE  = 2'd3
  } cycKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntLoad;  // a cycle start is accepted
    logic reqArm;   // granted state holds after this edge
  } arbStrobe_t;

endpackage

// File: rtl/bha_datapath.sv
module bha_datapath
  import bha_pkg::*;
#(
  parameter int INT_LEN    = 2,
  parameter int WIDE_LEN   = 3,
  parameter int NARROW_LEN = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdReq,
  input  logic       extPending,
  input  logic [1:0] cycKind,
  input  arbStrobe_t strobe,
  output logic       holdSeen,
  output logic       cycBusy,
  output logic       busReq
);

  localparam int MAX_A  = (INT_LEN > WIDE_LEN) ? INT_LEN : WIDE_LEN;
  localparam int MAX_L  = (MAX_A > NARROW_LEN) ? MAX_A : NARROW_LEN;
  localparam int CNT_W  = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (cycKind)
      KIND_INT:  loadVal = CNT_W'(INT_LEN - 1);
      KIND_WIDE: loadVal = CNT_W'(WIDE_LEN - 1);
      default:   loadVal = CNT_W'(NARROW_LEN - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdSeen <= 1'b0;
      remain   <= '0;
      busReq   <= 1'b0;
    end else begin
      holdSeen <= holdReq;
      busReq   <= strobe.reqArm & extPending;
      if (strobe.cntLoad)
        remain <= loadVal;
      else if (remain != '0)
        remain <= remain - 1'b1;
    end
  end

  assign cycBusy = (remain != '0);

endmodule

// File: rtl/bha_ctrl.sv
module bha_ctrl
  import bha_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdEn,
  input  logic       holdSeen,
  input  logic       cycBusy,
  input  logic       cycStart,
  output arbStrobe_t strobe,
  output logic       grant,
  output logic       drvEn,
  output logic       stall
);

  arbState_t state, nextState;
  logic      wantHold;

  assign wantHold = holdEn & holdSeen;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:    if (wantHold && !cycBusy && !cycStart) nextState = ST_GRANT;
      ST_GRANT:   if (!wantHold) nextState = ST_RELEASE;
      ST_RELEASE: nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.cntLoad = cycStart && (state == ST_IDLE);
    strobe.reqArm  = (nextState == ST_GRANT);
  end

  assign grant = (state == ST_GRANT);
  assign drvEn = (state == ST_IDLE);
  assign stall = (state != ST_IDLE);

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int INT_LEN    = 2,
  parameter int WIDE_LEN   = 3,
  parameter int NARROW_LEN = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       holdEn,
  input  logic       holdReq,
  input  logic       cycStart,
  input  logic [1:0] cycKind,
  input  logic       extPending,
  output logic       grant,
  output logic       drvEn,
  output logic       stall,
  output logic       busReq
);

  arbStrobe_t strobe;
  logic       holdSeen;
  logic       cycBusy;

  bha_datapath #(
    .INT_LEN(INT_LEN), .WIDE_LEN(WIDE_LEN), .NARROW_LEN(NARROW_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .extPending(extPending),
    .cycKind(cycKind), .strobe(strobe), .holdSeen(holdSeen),
    .cycBusy(cycBusy), .busReq(busReq)
  );

  bha_ctrl u_ctl (
    .clk(clk), .rstN(rstN), .holdEn(holdEn), .holdSeen(holdSeen),
    .cycBusy(cycBusy), .cycStart(cycStart), .strobe(strobe),
    .grant(grant), .drvEn(drvEn), .stall(stall)
  );

endmodule

// File: rtl/bha_checker.sv
module bha_checker (
  input logic clk,
  input logic rstN,
  input logic holdEn,
  input logic grant,
  input logic drvEn,
  input logic stall,
  input logic busReq,
  input logic cycBusy
);

  AST_FLOAT_WHILE_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> (!drvEn && stall)); // R6

  AST_GRANT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(holdEn)); // R2

  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(!cycBusy)); // R4

  AST_BUSREQ_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> grant); // R8

  AST_ACK_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(grant) |-> !drvEn); // R7

  AST_DRIVE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drvEn) |-> (!grant && $past(!grant))); // R7

endmodule

bind bus_hold_arbiter bha_checker u_chk (
  .clk(clk), .rstN(rstN), .holdEn(holdEn), .grant(grant), .drvEn(drvEn),
  .stall(stall), .busReq(busReq), .cycBusy(cycBusy)
);

// File: tb/sim_bus_hold_arbiter.sv
`timescale 1ns/1ps
module sim_bus_hold_arbiter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic holdEn = 1'b1;
  logic holdReq = 1'b0;
  logic cycStart = 1'b0;
  logic [1:0] cycKind = 2'd0;
  logic extPending = 1'b0;
  logic grant, drvEn, stall, busReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_hold_arbiter u0 (
    .clk(clk), .rstN(rstN), .holdEn(holdEn), .holdReq(holdReq),
    .cycStart(cycStart), .cycKind(cycKind), .extPending(extPending),
    .grant(grant), .drvEn(drvEn), .stall(stall), .busReq(busReq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // one edge: inputs already set at the falling edge, sample at next falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int lenOf(input int k);
    return (k == 0) ? 2 : (k == 1) ? 3 : 5;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 grant", grant, 1'b0);
    chk("R1 busReq", busReq, 1'b0);
    chk("R1 stall", stall, 1'b0);
    chk("R1 drvEn", drvEn, 1'b1);
    rstN = 1'b1;
    step();

    // R3/R4/R5/R6/R7 sweep: cycle start at edge S, request from edge H
    for (int k = 0; k < 3; k++) begin
      for (int h = 0; h < 10; h++) begin
        int s, g;
        s = 3;
        if (h + 1 < s) g = h + 1;
        else g = ((h + 1) > (s + lenOf(k))) ? h + 1 : s + lenOf(k);
        holdReq = 1'b0; cycStart = 1'b0;
        repeat (8) step();
        for (int t = 0; t < 15; t++) begin
          cycStart = (t == s);
          cycKind  = 2'(k);
          holdReq  = (t >= h);
          step();
          if (h + 1 < s) chk("R3 grant", grant, t >= g);
          else if (h + 1 == s) chk("R5 grant", grant, t >= g);
          else chk("R4 grant", grant, t >= g);
          chk("R6 drvEn", drvEn, !(t >= g));
          chk("R6 stall", stall, t >= g);
          chk("R8 busReq idle", busReq, 1'b0);
        end
        cycStart = 1'b0;
        holdReq = 1'b0;
        step();
        chk("R7 grant holds", grant, 1'b1);
        step();
        chk("R7 grant drops", grant, 1'b0);
        chk("R7 drvEn still off", drvEn, 1'b0);
        chk("R7 stall still on", stall, 1'b1);
        step();
        chk("R7 drvEn back", drvEn, 1'b1);
        chk("R7 stall clear", stall, 1'b0);
      end
    end

    // R8: pending external cycle while granted
    repeat (8) step();
    extPending = 1'b1;
    holdReq = 1'b1;
    step();
    chk("R8 no req before grant", busReq, 1'b0);
    step();
    chk("R8 grant", grant, 1'b1);
    chk("R8 req with grant", busReq, 1'b1);
    extPending = 1'b0;
    step();
    chk("R8 req drops", busReq, 1'b0);
    extPending = 1'b1;
    step();
    chk("R8 req rises", busReq, 1'b1);
    holdReq = 1'b0;
    step();
    chk("R8 req while still granted", busReq, 1'b1);
    step();
    chk("R8 req ends with grant", busReq, 1'b0);
    chk("R8 grant ended", grant, 1'b0);
    step();
    extPending = 1'b0;

    // R2: feature disabled
    holdEn = 1'b0;
    extPending = 1'b1;
    holdReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R2 grant", grant, 1'b0);
      chk("R2 busReq", busReq, 1'b0);
      chk("R2 drvEn", drvEn, 1'b1);
    end
    extPending = 1'b0;
    holdEn = 1'b1;
    step();
    chk("R3 grant on enable", grant, 1'b1);
    // R10: enable cleared while granted
    holdEn = 1'b0;
    step();
    chk("R10 grant drops", grant, 1'b0);
    chk("R10 drvEn still off", drvEn, 1'b0);
    step();
    chk("R10 drvEn back", drvEn, 1'b1);
    step();
    chk("R10 stays idle", grant, 1'b0);
    holdReq = 1'b0;
    holdEn = 1'b1;
    repeat (3) step();

    // R9: cycle start during stall is not accepted
    holdReq = 1'b1;
    repeat (2) step();
    chk("R9 granted", grant, 1'b1);
    holdReq = 1'b0;
    cycStart = 1'b1;
    cycKind = 2'd2;
    step();
    chk("R9 stall during start", stall, 1'b1);
    cycStart = 1'b0;
    holdReq = 1'b1;
    step();
    chk("R9 released", grant, 1'b0);
    step();
    chk("R9 idle", drvEn, 1'b1);
    step();
    chk("R9 regrant without busy cycle", grant, 1'b1);
    holdReq = 1'b0;
    repeat (4) step();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule